// File: doc/BRIEF.md
# Sectored Instruction Cache Tag Controller

This block keeps the bookkeeping for a small instruction cache built from eight sectors of 128 words each. Every fetch address is split into a 7-bit word offset and an upper tag. The tag is compared against all eight sector tags in the same cycle. The block reports hit, miss or bypass, together with the sector and word that the data array should use. The data array and the path to external program memory are outside this block. The block only decides which sector holds or receives a line, and which words of it are valid.

When a fetch misses on the tag, the block picks a victim sector. The victim is the unlocked sector lying deepest in an eight-entry recency stack. The victim is retagged, all of its word-valid bits are cleared, and it moves to the top of the stack. The external refill then raises a fill strobe for each word it writes, and each such strobe sets that word's valid bit. Other inputs lock or unlock single sectors, flush every valid bit at once, and turn the cache on or off. A change of the enable input reaches the fetch logic only after a fixed pipeline delay. A serial read-out streams tags, locks, the recency order and all valid bits without changing any of them.

The read-out has two named states. SER_IDLE moves to SER_SHIFT when `dbg_start` is sampled high, and the bit counter is cleared on that move. SER_SHIFT stays in place, advancing the counter once per cycle, until the last frame bit has been sent. It then returns to SER_IDLE.

Top module: `icache_ctrl`

## Requirements
- R1: After reset, sector i holds tag i, all valid bits are clear, and no sector is locked. The recency stack reads 0,1,...,7 from most to least recent. The effective cache enable is off.
- R2: An enabled fetch whose tag matches a sector and whose word is valid gives fetch_hit=1, fetch_miss=0 and fetch_bypass=0 in the same cycle. fetch_sector gives the matching sector and fetch_word gives address bits [6:0]. This holds for locked sectors as well.
- R3: An enabled fetch that matches a tag but finds the word invalid gives fetch_miss=1 and fetch_bypass=0, with fetch_sector set to the matching sector. No tag changes.
- R4: An enabled fetch that matches no tag, while at least one sector is unlocked, gives fetch_miss=1, fetch_bypass=0 and fetch_sector set to the victim. The victim is the unlocked sector deepest in the recency stack. At the next edge the victim takes the fetch tag and all its valid bits are cleared.
- R5: A fill strobe whose address tag matches a sector sets that word's valid bit at the next edge. A fill strobe whose tag matches no sector changes nothing.
- R6: Every enabled fetch that matches a tag or allocates a sector moves that sector to the top of the recency stack. The entries above its old place shift down by one.
- R7: A sector locked with lock_set is never chosen as a victim. If all sectors are locked, a tag-missing fetch gives fetch_miss=1, fetch_bypass=1 and fetch_sector=0, and no tag changes.
- R8: lock_clr makes a sector eligible as a victim again. If lock_set and lock_clr are both high in one cycle, lock_set wins.
- R9: flush clears every valid bit at the next edge. Tags, locks and recency order are kept.
- R10: A value on cache_en reaches the fetch logic after three rising edges. Fetches before that use the old mode. While the cache is disabled, every fetch gives fetch_miss=1, fetch_bypass=1 and fetch_hit=0, and the fetch changes no tag or recency state.
- R11: After dbg_start is sampled, dbg_sdo_vld is high for exactly 1128 cycles, sending one frame bit per cycle from bit 0 upward. Bits [9i+8:9i] hold the tag of sector i. Bits [72+i] hold the lock of sector i. Bits [80+3j+2:80+3j] hold stack entry j, where j=0 is the most recent. Bit 104+128s+w is the valid bit of sector s, word w.
- R12: A serial read-out leaves tags, locks, recency order and valid bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | Requested cache mode, applied after the delay |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | 16 | Fetch word address |
| fetch_hit | output | 1 | Fetch served from the cache |
| fetch_miss | output | 1 | Fetch not served from the cache |
| fetch_bypass | output | 1 | Fetch goes to memory without allocating |
| fetch_sector | output | 3 | Matched or victim sector |
| fetch_word | output | 7 | Word offset within the sector |
| fill_we | input | 1 | Refill wrote one word |
| fill_addr | input | 16 | Address of the refilled word |
| flush | input | 1 | Clear all valid bits |
| lock_set | input | 1 | Lock sector lock_sel |
| lock_clr | input | 1 | Unlock sector lock_sel |
| lock_sel | input | 3 | Sector for lock commands |
| dbg_start | input | 1 | Start a serial status read-out |
| dbg_sdo | output | 1 | Serial status bit |
| dbg_sdo_vld | output | 1 | dbg_sdo carries a frame bit |

## Verification
The hit, miss, bypass, sector and word outputs depend only on the current inputs and the stored state. The bench therefore samples them one nanosecond after it drives a fetch, in the same cycle. Tag, valid, lock and recency changes take effect at the next rising edge, so each is checked through a fetch in a later cycle or through the final serial frame. Each enable change is checked in the three cycles that still use the old mode and again in the first cycle after the third edge. Frame bit k is read in the k-th cycle after the edge that samples dbg_start, and the bench checks that dbg_sdo_vld drops right after the last bit.

// File: rtl/icache_pkg.sv
package icache_pkg;
    parameter int unsigned IC_ADDR_W = 16;
    parameter int unsigned IC_WORD_W = 7;
    parameter int unsigned IC_NSECT  = 8;
    parameter int unsigned IC_EN_DLY = 3;

    typedef enum logic {
        SER_IDLE,
        SER_SHIFT
    } ser_state_e;
endpackage

// File: rtl/icache_lru.sv
module icache_lru #(
    parameter int unsigned NSECT = 8,
    localparam int unsigned SEL_W = $clog2(NSECT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   touch_en,
    input  logic [SEL_W-1:0]       touch_sel,
    input  logic [NSECT-1:0]       lock_vec,
    output logic [SEL_W-1:0]       victim,
    output logic                   all_locked,
    output logic [NSECT*SEL_W-1:0] stack_flat
);
    logic [SEL_W-1:0] stack_q [NSECT];
    logic [SEL_W-1:0] stack_d [NSECT];
    logic [SEL_W-1:0] pos;

    always_comb begin
        pos = '0;
        for (int j = 0; j < int'(NSECT); j++) begin
            if (stack_q[j] == touch_sel) pos = SEL_W'(j);
        end
        stack_d = stack_q;
        if (touch_en) begin
            for (int j = 0; j < int'(NSECT); j++) begin
                if (j == 0) stack_d[j] = touch_sel;
                else if (j <= int'(pos)) stack_d[j] = stack_q[j-1];
            end
        end
    end

    // deepest unlocked entry wins because later iterations override
    always_comb begin
        victim     = '0;
        all_locked = 1'b1;
        for (int j = 0; j < int'(NSECT); j++) begin
            if (!lock_vec[stack_q[j]]) begin
                victim     = stack_q[j];
                all_locked = 1'b0;
            end
        end
    end

    always_comb begin
        for (int j = 0; j < int'(NSECT); j++) stack_flat[j*SEL_W +: SEL_W] = stack_q[j];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < int'(NSECT); j++) stack_q[j] <= SEL_W'(j);
        end else begin
            stack_q <= stack_d;
        end
    end

    logic [NSECT-1:0] seen;
    always_comb begin
        seen = '0;
        for (int j = 0; j < int'(NSECT); j++) seen[stack_q[j]] = 1'b1;
    end

    a_r1_stack_is_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == NSECT);
    a_r7_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !all_locked |-> !lock_vec[victim]);
    a_r6_touch_to_top: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> stack_q[0] == $past(touch_sel));
endmodule

// File: rtl/icache_tags.sv
module icache_tags #(
    parameter int unsigned NSECT  = 8,
    parameter int unsigned TAG_W  = 9,
    parameter int unsigned WORD_W = 7,
    localparam int unsigned SEL_W = $clog2(NSECT),
    localparam int unsigned WORDS = 1 << WORD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TAG_W-1:0]         look_tag,
    input  logic [WORD_W-1:0]        look_off,
    input  logic                     alloc_en,
    input  logic [SEL_W-1:0]         alloc_sel,
    input  logic                     fill_we,
    input  logic [TAG_W-1:0]         fill_tag,
    input  logic [WORD_W-1:0]        fill_off,
    input  logic                     flush,
    input  logic                     lock_set,
    input  logic                     lock_clr,
    input  logic [SEL_W-1:0]         lock_sel,
    output logic                     tag_hit,
    output logic [SEL_W-1:0]         hit_sel,
    output logic                     word_vld,
    output logic [NSECT-1:0]         lock_vec,
    output logic [NSECT*TAG_W-1:0]   tags_flat,
    output logic [NSECT*WORDS-1:0]   valid_flat
);
    logic [TAG_W-1:0]            tags_q [NSECT];
    logic [NSECT-1:0][WORDS-1:0] vbits_q;
    logic [NSECT-1:0]            lock_q;
    logic [NSECT-1:0]            look_mask, fill_mask;
    logic [SEL_W-1:0]            fill_sel;

    always_comb begin
        hit_sel  = '0;
        fill_sel = '0;
        for (int i = 0; i < int'(NSECT); i++) begin
            look_mask[i] = (tags_q[i] == look_tag);
            fill_mask[i] = (tags_q[i] == fill_tag);
            if (look_mask[i]) hit_sel  = SEL_W'(i);
            if (fill_mask[i]) fill_sel = SEL_W'(i);
        end
        tag_hit  = |look_mask;
        word_vld = vbits_q[hit_sel][look_off];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NSECT); i++) tags_q[i] <= TAG_W'(i);
            vbits_q <= '0;
            lock_q  <= '0;
        end else begin
            if (alloc_en) begin
                tags_q[alloc_sel]  <= look_tag;
                vbits_q[alloc_sel] <= '0;
            end
            if (fill_we && |fill_mask) vbits_q[fill_sel][fill_off] <= 1'b1;
            if (flush) vbits_q <= '0;
            if (lock_set)      lock_q[lock_sel] <= 1'b1;
            else if (lock_clr) lock_q[lock_sel] <= 1'b0;
        end
    end

    always_comb begin
        for (int i = 0; i < int'(NSECT); i++) tags_flat[i*TAG_W +: TAG_W] = tags_q[i];
    end
    assign valid_flat = vbits_q;
    assign lock_vec   = lock_q;

    a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_mask));
    a_r4_retag: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> tags_q[$past(alloc_sel)] == $past(look_tag));
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> vbits_q == '0);
    a_r8_lock_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        lock_set |=> lock_q[$past(lock_sel)]);
endmodule

// File: rtl/icache_ser.sv
module icache_ser
    import icache_pkg::*;
#(
    parameter int unsigned STAT_W = 1128,
    localparam int unsigned CNT_W = $clog2(STAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [STAT_W-1:0] status,
    output logic              sdo,
    output logic              sdo_vld
);
    ser_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SER_IDLE: begin
                if (start) begin
                    state_d = SER_SHIFT;
                    cnt_d   = '0;
                end
            end
            SER_SHIFT: begin
                if (cnt_q == CNT_W'(STAT_W - 1)) state_d = SER_IDLE;
                else cnt_d = cnt_q + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SER_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        sdo_vld = (state_q == SER_SHIFT);
        sdo     = sdo_vld ? status[cnt_q] : 1'b0;
    end

    a_r11_shift_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_vld) |-> $past(start));
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int unsigned ADDR_W = IC_ADDR_W,
    parameter int unsigned WORD_W = IC_WORD_W,
    parameter int unsigned NSECT  = IC_NSECT,
    parameter int unsigned EN_DLY = IC_EN_DLY,
    localparam int unsigned SEL_W = $clog2(NSECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_hit,
    output logic              fetch_miss,
    output logic              fetch_bypass,
    output logic [SEL_W-1:0]  fetch_sector,
    output logic [WORD_W-1:0] fetch_word,
    input  logic              fill_we,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              flush,
    input  logic              lock_set,
    input  logic              lock_clr,
    input  logic [SEL_W-1:0]  lock_sel,
    input  logic              dbg_start,
    output logic              dbg_sdo,
    output logic              dbg_sdo_vld
);
    localparam int unsigned TAG_W  = ADDR_W - WORD_W;
    localparam int unsigned WORDS  = 1 << WORD_W;
    localparam int unsigned STAT_W = NSECT * (TAG_W + 1 + SEL_W + WORDS);

    logic [EN_DLY-1:0] en_pipe;
    logic              en_eff;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_pipe <= '0;
        end else begin
            en_pipe[0] <= cache_en;
            for (int k = 1; k < int'(EN_DLY); k++) en_pipe[k] <= en_pipe[k-1];
        end
    end
    assign en_eff = en_pipe[EN_DLY-1];

    logic                     tag_hit, word_vld, all_locked, look, alloc_en, touch_en;
    logic [SEL_W-1:0]         hit_sel, victim, touch_sel;
    logic [NSECT-1:0]         lock_vec;
    logic [NSECT*TAG_W-1:0]   tags_flat;
    logic [NSECT*WORDS-1:0]   valid_flat;
    logic [NSECT*SEL_W-1:0]   stack_flat;

    always_comb begin
        look         = fetch_valid && en_eff;
        alloc_en     = look && !tag_hit && !all_locked;
        touch_en     = look && (tag_hit || !all_locked);
        touch_sel    = tag_hit ? hit_sel : victim;
        fetch_hit    = look && tag_hit && word_vld;
        fetch_miss   = fetch_valid && !fetch_hit;
        fetch_bypass = fetch_valid && (!en_eff || (!tag_hit && all_locked));
        fetch_sector = tag_hit ? hit_sel : (all_locked ? '0 : victim);
        fetch_word   = fetch_addr[WORD_W-1:0];
    end

    icache_tags #(.NSECT(NSECT), .TAG_W(TAG_W), .WORD_W(WORD_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_tag   (fetch_addr[ADDR_W-1:WORD_W]),
        .look_off   (fetch_addr[WORD_W-1:0]),
        .alloc_en   (alloc_en),
        .alloc_sel  (victim),
        .fill_we    (fill_we),
        .fill_tag   (fill_addr[ADDR_W-1:WORD_W]),
        .fill_off   (fill_addr[WORD_W-1:0]),
        .flush      (flush),
        .lock_set   (lock_set),
        .lock_clr   (lock_clr),
        .lock_sel   (lock_sel),
        .tag_hit    (tag_hit),
        .hit_sel    (hit_sel),
        .word_vld   (word_vld),
        .lock_vec   (lock_vec),
        .tags_flat  (tags_flat),
        .valid_flat (valid_flat)
    );

    icache_lru #(.NSECT(NSECT)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_sel  (touch_sel),
        .lock_vec   (lock_vec),
        .victim     (victim),
        .all_locked (all_locked),
        .stack_flat (stack_flat)
    );

    icache_ser #(.STAT_W(STAT_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (dbg_start),
        .status  ({valid_flat, stack_flat, lock_vec, tags_flat}),
        .sdo     (dbg_sdo),
        .sdo_vld (dbg_sdo_vld)
    );

    a_r10_off_keeps_tags: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff |=> $stable(tags_flat));
    a_r10_off_keeps_order: assert property (@(posedge clk) disable iff (!rst_n)
        !en_eff |=> $stable(stack_flat));
    a_r7_full_lock_no_retag: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_bypass && !flush) |=> $stable(tags_flat));
endmodule

// File: tb/icache_ctrl_tb.sv
`timescale 1ns/1ps
module icache_ctrl_tb;
    localparam int FRAME_W = 1128;
    localparam logic [2:0] OP_FETCH = 3'd1, OP_FILL = 3'd2, OP_LOCK = 3'd3,
                           OP_UNLK = 3'd4, OP_FLUSH = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] addr;
        logic        hit;
        logic        miss;
        logic        byp;
        logic [2:0]  sec;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{OP_FILL,  16'h0485, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5},  // R5 fill s7 w5
        '{OP_FETCH, 16'h0485, 1'b1, 1'b0, 1'b0, 3'd7, 4'd2},  // R2
        '{OP_FETCH, 16'h0486, 1'b0, 1'b1, 1'b0, 3'd7, 4'd3},  // R3
        '{OP_FETCH, 16'h0003, 1'b0, 1'b1, 1'b0, 3'd0, 4'd3},  // R3
        '{OP_FILL,  16'h0003, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5},  // R5
        '{OP_FETCH, 16'h0003, 1'b1, 1'b0, 1'b0, 3'd0, 4'd2},  // R2
        '{OP_FETCH, 16'h1000, 1'b0, 1'b1, 1'b0, 3'd6, 4'd4},  // R4 victim 6
        '{OP_LOCK,  16'h0005, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7},  // R7
        '{OP_LOCK,  16'h0004, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7},  // R7
        '{OP_FETCH, 16'h1080, 1'b0, 1'b1, 1'b0, 3'd3, 4'd7},  // R7 skips 5,4
        '{OP_FILL,  16'h1080, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5},  // R5
        '{OP_FILL,  16'h2000, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5},  // R5 no match
        '{OP_FETCH, 16'h1080, 1'b1, 1'b0, 1'b0, 3'd3, 4'd2},  // R2
        '{OP_FLUSH, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 4'd9},  // R9
        '{OP_FETCH, 16'h1080, 1'b0, 1'b1, 1'b0, 3'd3, 4'd9},  // R9 tag kept
        '{OP_FETCH, 16'h0485, 1'b0, 1'b1, 1'b0, 3'd7, 4'd9},  // R9
        '{OP_UNLK,  16'h0004, 1'b0, 1'b0, 1'b0, 3'd0, 4'd8},  // R8
        '{OP_FETCH, 16'h0200, 1'b0, 1'b1, 1'b0, 3'd4, 4'd6},  // R6 lifts s4
        '{OP_FETCH, 16'h2000, 1'b0, 1'b1, 1'b0, 3'd2, 4'd6},  // R6 victim 2
        '{OP_UNLK,  16'h0005, 1'b0, 1'b0, 1'b0, 3'd0, 4'd8},  // R8
        '{OP_FETCH, 16'h2080, 1'b0, 1'b1, 1'b0, 3'd5, 4'd8},  // R8 victim 5
        '{OP_LOCK,  16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7},
        '{OP_LOCK,  16'h0001, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7},
        '{OP_LOCK,  16'h0002, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7},
        '{OP_LOCK,  16'h0003, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7},
        '{OP_LOCK,  16'h0004, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7},
        '{OP_LOCK,  16'h0005, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7},
        '{OP_LOCK,  16'h0006, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7},
        '{OP_LOCK,  16'h0007, 1'b0, 1'b0, 1'b0, 3'd0, 4'd7},
        '{OP_FETCH, 16'h2100, 1'b0, 1'b1, 1'b1, 3'd0, 4'd7},  // R7 all locked
        '{OP_FETCH, 16'h2000, 1'b0, 1'b1, 1'b0, 3'd2, 4'd7},  // R7 locked match
        '{OP_FILL,  16'h2001, 1'b0, 1'b0, 1'b0, 3'd0, 4'd5},  // R5
        '{OP_FETCH, 16'h2001, 1'b1, 1'b0, 1'b0, 3'd2, 4'd2}   // R2 locked hit
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b0, fetch_valid = 1'b0, fill_we = 1'b0, flush = 1'b0;
    logic        lock_set = 1'b0, lock_clr = 1'b0, dbg_start = 1'b0;
    logic [15:0] fetch_addr = '0, fill_addr = '0;
    logic [2:0]  lock_sel = '0;
    logic        fetch_hit, fetch_miss, fetch_bypass, dbg_sdo, dbg_sdo_vld;
    logic [2:0]  fetch_sector;
    logic [6:0]  fetch_word;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    icache_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_hit(fetch_hit), .fetch_miss(fetch_miss), .fetch_bypass(fetch_bypass),
        .fetch_sector(fetch_sector), .fetch_word(fetch_word),
        .fill_we(fill_we), .fill_addr(fill_addr), .flush(flush),
        .lock_set(lock_set), .lock_clr(lock_clr), .lock_sel(lock_sel),
        .dbg_start(dbg_start), .dbg_sdo(dbg_sdo), .dbg_sdo_vld(dbg_sdo_vld)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fetch_valid = 1'b0; fill_we = 1'b0; flush = 1'b0;
        lock_set = 1'b0; lock_clr = 1'b0; dbg_start = 1'b0;
    endtask

    task automatic chk_fetch(input string req, input logic h, input logic m,
                             input logic b, input logic [2:0] s);
        chk(req, "hit", fetch_hit, h);
        chk(req, "miss", fetch_miss, m);
        chk(req, "bypass", fetch_bypass, b);
        if (!b) begin
            chk(req, "sector", fetch_sector, s);
            chk(req, "word", fetch_word, fetch_addr[6:0]);
        end
    endtask

    task automatic read_frame(output logic [FRAME_W-1:0] f);
        int bad_vld;
        bad_vld = 0;
        @(negedge clk); idle_inputs(); dbg_start = 1'b1;
        @(negedge clk); dbg_start = 1'b0;
        for (int k = 0; k < FRAME_W; k++) begin
            if (dbg_sdo_vld !== 1'b1) bad_vld++;
            f[k] = dbg_sdo;
            @(negedge clk);
        end
        chk("R11", "vld gaps", 64'(bad_vld), 0);
        chk("R11", "vld after last", dbg_sdo_vld, 1'b0);
    endtask

    task automatic cmp_frame(input string req, input logic [FRAME_W-1:0] act,
                             input int tg[8], input logic [7:0] lk, input int st[8],
                             input logic [1023:0] vb);
        for (int i = 0; i < 8; i++) chk(req, $sformatf("tag s%0d", i), act[i*9 +: 9], 64'(tg[i]));
        chk(req, "locks", act[72 +: 8], lk);
        for (int j = 0; j < 8; j++) chk(req, $sformatf("stack %0d", j), act[80 + j*3 +: 3], 64'(st[j]));
        chk(req, "valid bits", 64'($countones(act[104 +: 1024] ^ vb)), 0);
    endtask

    initial begin
        logic [FRAME_W-1:0] fr;
        logic [1023:0]      vb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset outputs
        chk("R1", "hit idle", fetch_hit, 1'b0);
        chk("R1", "miss idle", fetch_miss, 1'b0);
        chk("R11", "vld idle", dbg_sdo_vld, 1'b0);
        // R1 R11 reset frame
        read_frame(fr);
        cmp_frame("R1", fr, '{0,1,2,3,4,5,6,7}, 8'h00, '{0,1,2,3,4,5,6,7}, '0);

        // R10 disabled after reset: tag 8 fetch must not allocate
        @(negedge clk); idle_inputs(); fetch_valid = 1'b1; fetch_addr = 16'h0400;
        #1; chk_fetch("R10", 1'b0, 1'b1, 1'b1, 3'd0);
        // R10 enable takes three edges
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); idle_inputs(); cache_en = 1'b1;
            fetch_valid = 1'b1; fetch_addr = 16'h0480;
            #1;
            if (k < 3) chk_fetch("R10", 1'b0, 1'b1, 1'b1, 3'd0);
            else       chk_fetch("R10", 1'b0, 1'b1, 1'b0, 3'd7);
        end

        for (int v = 0; v < NV; v++) begin
            @(negedge clk); idle_inputs();
            unique case (VEC[v].op)
                OP_FETCH: begin fetch_valid = 1'b1; fetch_addr = VEC[v].addr; end
                OP_FILL:  begin fill_we = 1'b1; fill_addr = VEC[v].addr; end
                OP_LOCK:  begin lock_set = 1'b1; lock_sel = VEC[v].addr[2:0]; end
                OP_UNLK:  begin lock_clr = 1'b1; lock_sel = VEC[v].addr[2:0]; end
                OP_FLUSH: flush = 1'b1;
                default:  ;
            endcase
            #1;
            if (VEC[v].op == OP_FETCH)
                chk_fetch($sformatf("R%0d", VEC[v].req), VEC[v].hit, VEC[v].miss,
                          VEC[v].byp, VEC[v].sec);
        end

        // R8 set and clear together: set wins, sector 0 stays locked
        @(negedge clk); idle_inputs(); lock_set = 1'b1; lock_clr = 1'b1; lock_sel = 3'd0;

        // R4 R5 R7 R9 R11 final frame
        vb = '0;
        vb[2*128 + 1] = 1'b1;
        read_frame(fr);
        cmp_frame("R11", fr, '{0,1,64,33,4,65,32,9}, 8'hFF, '{2,5,4,7,3,6,0,1}, vb);

        // R12 state untouched by the read-out
        @(negedge clk); idle_inputs(); fetch_valid = 1'b1; fetch_addr = 16'h2001;
        #1; chk_fetch("R12", 1'b1, 1'b0, 1'b0, 3'd2);

        // R10 disable also delayed by three edges
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); idle_inputs(); cache_en = 1'b0;
            fetch_valid = 1'b1; fetch_addr = 16'h2001;
            #1;
            if (k < 3) chk_fetch("R10", 1'b1, 1'b0, 1'b0, 3'd2);
            else       chk_fetch("R10", 1'b0, 1'b1, 1'b1, 3'd0);
        end
        @(negedge clk); idle_inputs();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule